// File: doc/BRIEF.md
# Read-Only Display Channel Port

This block is the serial target that one display channel uses to fetch identification data from its own 256-byte bank. It watches a two-wire serial bus (clock and data, already filtered), decodes the target header, and drives only a pull-down enable for the open-drain data line. Toward the bank storage it presents an 8-bit read address and takes the byte stored there back on the same cycle. A port-enable input, taken from the board's protect strap, decides whether this channel may answer at all.

The port can only read. A host loads the address counter with a write-direction header followed by one word address. A repeated START with a read-direction header then streams bytes from that location. A read header on its own resumes from the counter. Every byte the host acknowledges moves the counter forward, and the counter wraps at the top of the bank. The port refuses bytes sent after the word address, and any START puts it back into the header phase.

Top module: `ddc_read_port`

## Requirements
- R1: The port acknowledges a header only when its upper seven bits, sent first, are 1010000. Bit 0 is the direction (1 = read, 0 = write). Any other header leaves the data line high in the ninth clock, and the port ignores the rest of that transfer.
- R2: While `port_disable_i` is high the port acknowledges nothing, and `sda_pull_o` is low from the next clock onward.
- R3: A write header, an acknowledged word address, a repeated START and a read header make the port send the byte at that word address, most significant bit first.
- R4: After each byte the counter advances by one. If the host acknowledges, the next byte follows from the new address, and 0xFF is followed by 0x00 of the same bank.
- R5: A host NACK after a data byte ends the transfer. The port then leaves the data line released for any further clocks until a STOP or a START.
- R6: A read header with no word address before it returns the byte one above the last address read. After a word address with no read, it returns the byte at that word address.
- R7: The port samples data on rising clock edges. It changes `sda_pull_o` only while the bus clock is low, after a falling edge.
- R8: A byte sent after the word address in a write-direction transfer gets no acknowledge and leaves the address counter unchanged.
- R9: A START followed directly by a STOP, or a STOP partway through a header, cancels the command with no acknowledge. The port then accepts the next transfer normally.
- R10: A START in any state returns the port to the header phase. A new transfer started partway through a word address completes correctly.
- R11: After reset the address counter is 0x00 and the data line is released. A read header as the first command returns the byte at address 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, many times faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Filtered bus clock |
| sda_i | input | 1 | Filtered bus data as seen on the wire |
| port_disable_i | input | 1 | High: port silent (protect strap high) |
| sda_pull_o | output | 1 | High: pull the data line low |
| mem_addr_o | output | 8 | Read address into the bank |
| mem_rdata_i | input | 8 | Byte stored at `mem_addr_o` |

## Verification
The assertions assume that the bus clock holds each level for several block clocks, longer than the synchroniser delay. They also assume the host changes data only while the clock is low, except when it forms a START or a STOP. The check that `sda_pull_o` moves only while the clock is low, and the check that the protect input silences the port, hold only under those assumptions. The bench drives every bus edge six block clocks after the previous one. It raises the protect input only between transfers, and it never forms a START while the port could be holding the line low.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_ACK_DEV,
        ST_WADDR,
        ST_ACK_ADR,
        ST_WDATA,
        ST_TX,
        ST_TX_ACK,
        ST_TX_LOAD,
        ST_IGNORE
    } port_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

endpackage

// File: rtl/ddc_line_events.sv
module ddc_line_events #(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output ddc_pkg::bus_ev_t ev_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_prev;
        logic                   sda_prev;
    } line_t;

    localparam int LAST = SYNC_STAGES - 1;

    line_t q, d;

    always_comb begin
        d = q;
        d.scl_sh[0] = scl_i;
        d.sda_sh[0] = sda_i;
        for (int k = 1; k < SYNC_STAGES; k++) begin
            d.scl_sh[k] = q.scl_sh[k-1];
            d.sda_sh[k] = q.sda_sh[k-1];
        end
        d.scl_prev = q.scl_sh[LAST];
        d.sda_prev = q.sda_sh[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    // Edge and bus-condition decode on the synchronised copies
    always_comb begin
        ev_o.rise  = q.scl_sh[LAST] & ~q.scl_prev;
        ev_o.fall  = ~q.scl_sh[LAST] & q.scl_prev;
        ev_o.start = q.scl_sh[LAST] & q.scl_prev & q.sda_prev & ~q.sda_sh[LAST];
        ev_o.stop  = q.scl_sh[LAST] & q.scl_prev & ~q.sda_prev & q.sda_sh[LAST];
        ev_o.sda   = q.sda_sh[LAST];
    end

endmodule

// File: rtl/ddc_addr_counter.sv
module ddc_addr_counter #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] addr_d, addr_q;

    // Natural binary wrap keeps the counter inside its own bank
    always_comb begin
        addr_d = addr_q;
        if (load_i) begin
            addr_d = load_val_i;
        end else if (inc_i) begin
            addr_d = addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/ddc_read_port.sv
module ddc_read_port #(
    parameter int              DATA_W      = 8,
    parameter int              ADDR_W      = 8,
    parameter int              SYNC_STAGES = 2,
    parameter logic [DATA_W-2:0] DEV_ID    = 7'b1010000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              port_disable_i,
    output logic              sda_pull_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    import ddc_pkg::*;

    localparam int              CNT_W   = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        port_state_e       state;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-2:0] rx;
        logic [DATA_W-1:0] tx;
        logic              rw;
        logic              ack_on;
        logic              pull;
    } ctl_t;

    ctl_t              q, d;
    bus_ev_t           ev;
    logic              addr_load;
    logic              addr_inc;
    logic [ADDR_W-1:0] load_val;
    logic              stop_seen;
    port_state_e       cur_state;

    ddc_line_events #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    ddc_addr_counter #(
        .ADDR_W(ADDR_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (addr_load),
        .load_val_i (load_val),
        .inc_i      (addr_inc),
        .addr_o     (mem_addr_o)
    );

    always_comb begin
        d         = q;
        addr_load = 1'b0;
        addr_inc  = 1'b0;
        load_val  = ADDR_W'({q.rx, ev.sda});

        if (port_disable_i) begin
            d.state  = ST_IDLE;
            d.pull   = 1'b0;
            d.ack_on = 1'b0;
        end else if (ev.start) begin
            // Resynchronise to the header phase from any state
            d.state  = ST_DEV;
            d.cnt    = '0;
            d.pull   = 1'b0;
            d.ack_on = 1'b0;
        end else if (ev.stop) begin
            d.state  = ST_IDLE;
            d.pull   = 1'b0;
            d.ack_on = 1'b0;
        end else begin
            unique case (q.state)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (ev.rise) begin
                        d.rx  = {q.rx[DATA_W-3:0], ev.sda};
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == BIT_LAST) begin
                            if (q.state == ST_DEV) begin
                                d.rw    = ev.sda;
                                d.state = (q.rx == DEV_ID) ? ST_ACK_DEV : ST_IGNORE;
                            end else if (q.state == ST_WADDR) begin
                                addr_load = 1'b1;
                                d.state   = ST_ACK_ADR;
                            end else begin
                                // Extra byte after the word address: refused
                                d.state = ST_IGNORE;
                            end
                        end
                    end
                end
                ST_ACK_DEV, ST_ACK_ADR: begin
                    if (ev.fall) begin
                        if (!q.ack_on) begin
                            d.ack_on = 1'b1;
                            d.pull   = 1'b1;
                        end else begin
                            d.ack_on = 1'b0;
                            d.pull   = 1'b0;
                            d.cnt    = '0;
                            if (q.state == ST_ACK_ADR) begin
                                d.state = ST_WDATA;
                            end else if (q.rw) begin
                                d.tx    = mem_rdata_i << 1;
                                d.pull  = ~mem_rdata_i[DATA_W-1];
                                d.state = ST_TX;
                            end else begin
                                d.state = ST_WADDR;
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (ev.fall) begin
                        if (q.cnt == BIT_LAST) begin
                            d.pull  = 1'b0;
                            d.state = ST_TX_ACK;
                        end else begin
                            d.cnt  = q.cnt + 1'b1;
                            d.pull = ~q.tx[DATA_W-1];
                            d.tx   = q.tx << 1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev.rise) begin
                        addr_inc = 1'b1;
                        d.state  = ev.sda ? ST_IGNORE : ST_TX_LOAD;
                    end
                end
                ST_TX_LOAD: begin
                    if (ev.fall) begin
                        d.tx    = mem_rdata_i << 1;
                        d.pull  = ~mem_rdata_i[DATA_W-1];
                        d.cnt   = '0;
                        d.state = ST_TX;
                    end
                end
                default: begin
                    d.pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, cnt: '0, rx: '0, tx: '0,
                   rw: 1'b0, ack_on: 1'b0, pull: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o = q.pull;
    assign stop_seen  = ev.stop;
    assign cur_state  = q.state;

endmodule

// File: rtl/ddc_read_port_chk.sv
module ddc_read_port_chk #(
    parameter int ADDR_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 scl_i,
    input logic                 port_disable_i,
    input logic                 sda_pull_o,
    input logic [ADDR_W-1:0]    mem_addr_o,
    input logic                 addr_load,
    input logic                 stop_seen,
    input ddc_pkg::port_state_e cur_state
);
    import ddc_pkg::*;

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        port_disable_i |=> !sda_pull_o); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_addr_o != $past(mem_addr_o)) && !$past(addr_load))
        |-> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1))); // R4

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_i); // R7

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> !sda_pull_o); // R9

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_IDLE) |-> !sda_pull_o); // R11

endmodule

bind ddc_read_port ddc_read_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_i          (scl_i),
    .port_disable_i (port_disable_i),
    .sda_pull_o     (sda_pull_o),
    .mem_addr_o     (mem_addr_o),
    .addr_load      (addr_load),
    .stop_seen      (stop_seen),
    .cur_state      (cur_state)
);

// File: tb/ddc_read_port_bench.sv
module ddc_read_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HP         = 6;
    localparam int NVEC       = 4;

    // {word address, number of bytes read in sequence}
    localparam logic [11:0] VEC [NVEC] = '{
        {8'h10, 4'd2}, {8'hFE, 4'd3}, {8'h00, 4'd1}, {8'h7F, 4'd2}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       dis = 1'b0;
    logic       sda_pull;
    logic [7:0] mem_addr;
    logic [7:0] mem_rdata;
    logic       sda_line;

    int errors = 0;
    int checks = 0;
    int viol   = 0;
    logic scl_pos = 1'b1;
    logic pull_last = 1'b0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] bank(input logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'hC3;
    endfunction

    assign sda_line  = m_sda & ~sda_pull;
    assign mem_rdata = bank(mem_addr);

    ddc_read_port u_ddc_read_port (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_i          (m_scl),
        .sda_i          (sda_line),
        .port_disable_i (dis),
        .sda_pull_o     (sda_pull),
        .mem_addr_o     (mem_addr),
        .mem_rdata_i    (mem_rdata)
    );

    // R7 monitor: the pull-down may only move while SCL is low
    always @(posedge clk) scl_pos <= m_scl;
    always @(negedge clk) begin
        if (rst_n && (sda_pull != pull_last) && scl_pos) viol++;
        pull_last = sda_pull;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic do_start();
        m_sda = 1'b1; hp();
        m_scl = 1'b1; hp();
        m_sda = 1'b0; hp();
        m_scl = 1'b0; hp();
    endtask

    task automatic do_stop();
        m_sda = 1'b0; hp();
        m_scl = 1'b1; hp();
        m_sda = 1'b1; hp();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; hp();
        m_scl = 1'b1; hp();
        m_scl = 1'b0; hp();
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; hp();
        m_scl = 1'b1; hp();
        b = sda_line;
        m_scl = 1'b0; hp();
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic rbyte(output logic [7:0] v, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~mack);
    endtask

    task automatic rand_read(input logic [7:0] a, input int n);
        logic ack;
        logic [7:0] v;
        do_start();
        wbyte(8'hA0, ack); chk("R1 write header ack", ack, 1);
        wbyte(a, ack);     chk("R3 word address ack", ack, 1);
        do_start();
        wbyte(8'hA1, ack); chk("R3 read header ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            rbyte(v, i < n - 1);
            chk("R3 R4 sequential byte", v, bank(8'(a + i)));
        end
        do_stop();
    endtask

    task automatic cur_read(input logic [7:0] exp_a, input string tag);
        logic ack;
        logic [7:0] v;
        do_start();
        wbyte(8'hA1, ack); chk(tag, ack, 1);
        rbyte(v, 1'b0);
        chk(tag, v, bank(exp_a));
        do_stop();
    endtask

    initial begin
        logic ack;
        logic b;
        logic [7:0] v;
        int ones;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        hp();
        chk("R11 reset address", mem_addr, 8'h00);
        chk("R11 reset pull", sda_pull, 0);
        cur_read(8'h00, "R11 first current read");

        for (int i = 0; i < NVEC; i++) begin
            rand_read(VEC[i][11:4], int'(VEC[i][3:0]));
        end
        cur_read(8'h81, "R6 current read after sequence");

        // R1: foreign header refused
        do_start();
        wbyte(8'hA2, ack); chk("R1 foreign header nack", ack, 0);
        wbyte(8'hA1, ack); chk("R1 rest ignored", ack, 0);
        do_stop();

        // R2: protect high silences the port
        dis = 1'b1; hp();
        do_start();
        wbyte(8'hA1, ack); chk("R2 disabled nack", ack, 0);
        do_stop();
        dis = 1'b0; hp();

        // R8: data byte after word address refused, counter kept
        do_start();
        wbyte(8'hA0, ack); chk("R8 header ack", ack, 1);
        wbyte(8'h40, ack); chk("R8 word address ack", ack, 1);
        wbyte(8'h99, ack); chk("R8 data byte nack", ack, 0);
        do_stop();
        cur_read(8'h40, "R8 R6 read from word address");

        // R5: NACK ends transmission
        do_start();
        wbyte(8'hA0, ack);
        wbyte(8'h20, ack);
        do_start();
        wbyte(8'hA1, ack);
        rbyte(v, 1'b0);
        chk("R5 byte before nack", v, bank(8'h20));
        ones = 0;
        for (int i = 0; i < 9; i++) begin
            recv_bit(b);
            ones += int'(b);
        end
        chk("R5 line released after nack", ones, 9);
        do_stop();
        cur_read(8'h21, "R5 R6 counter after nack");

        // R9: cancel by START then STOP, and STOP inside a header
        do_start();
        do_stop();
        chk("R9 no pull after cancel", sda_pull, 0);
        do_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        do_stop();
        chk("R9 no pull after partial header", sda_pull, 0);
        cur_read(8'h22, "R9 transfer after cancel");

        // R10: START partway through a word address resynchronises
        do_start();
        wbyte(8'hA0, ack);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        do_start();
        wbyte(8'hA0, ack); chk("R10 header after resync", ack, 1);
        wbyte(8'h50, ack); chk("R10 word address", ack, 1);
        do_start();
        wbyte(8'hA1, ack);
        rbyte(v, 1'b0);
        chk("R10 byte after resync", v, bank(8'h50));
        do_stop();

        chk("R7 pull changed while SCL high", viol, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule